// File: doc/BRIEF.md
# Boot-Mode Flash Wait-State Controller

This block sits between a processor's external memory bus and a flash device that can read in two ways: a slow asynchronous mode and a fast synchronous burst mode. The flash always powers up asynchronous, yet the processor may fetch from its first cycle as if burst reads were already possible. The controller keeps track of the flash's current read mode. While the flash is asynchronous, it holds the processor off with a programmable number of wait cycles and keeps its ready output low. It also drives the flash chip enable, the address-valid strobe and a divided memory clock for every access.

Boot software reconfigures the flash for burst reads and then tells the controller, in one of two ways chosen at build time. It can write a control register that the processor reaches through the bus, or it can drive a general-purpose input level. After the switch, ready follows the flash's own wait output, and no counted wait cycles are added. Two build-time choices are available for the flash address interface. With the address-valid strobe, consecutive accesses keep the chip enabled. Without the strobe, the chip enable is dropped for one cycle between consecutive accesses so that the flash latches the new address.

Top module: `flash_boot_wsc`

## Requirements
- R1: After reset the block is in asynchronous mode (`burst_mode`=0), with `flash_ce_n`=1, `flash_adv_n`=1, `cpu_ready`=0 and `cfg_err`=0. The control register resets to a wait count of 15, burst disabled and a clock period of 7.
- R2: An asynchronous flash read that is accepted on a clock edge keeps `cpu_ready` low for wait-count + 1 cycles: one address cycle followed by wait-count wait cycles. Then `cpu_ready` is high for exactly one cycle. `flash_ce_n` is low from the address cycle through the ready cycle.
- R3: A start with `cpu_reg_wr`=1 writes `cpu_wdata` to the control register. Bit 0 is burst enable, bits 4:1 are the wait count and bits 7:5 are the flash clock period in system cycles. `cpu_ready` is high in the next cycle, and the chip enable and the strobe stay inactive.
- R4: In burst mode, an access holds `cpu_ready` low only in its address cycle. After that, `cpu_ready` equals the inverse of `flash_wait`, and the wait count has no effect.
- R5: With `MODE_SRC`=0, the mode is register bit 0 and `gpio_burst` is ignored. With `MODE_SRC`=1, the mode is `gpio_burst` after a two-flop synchronizer, and register bit 0 is ignored.
- R6: The mode is sampled when an access is accepted. A change of mode during an access does not alter that access's wait behaviour.
- R7: With `USE_ADV`=1, `flash_adv_n` is low for exactly the address cycle of each flash read. A start accepted in a ready cycle goes straight to the next address cycle, with `flash_ce_n` held low and the strobe pulsing again.
- R8: With `USE_ADV`=0, `flash_adv_n` stays high. A start accepted in a ready cycle while the chip is enabled first spends one cycle with `flash_ce_n`=1 before the address cycle.
- R9: `flash_clk` has a period of P system cycles and is high for floor(P/2) of them. `cfg_err` is 1 when P*`SYS_CLK_NS` < `MIN_CLK_NS`. While `cfg_err` is 1, `flash_clk` is held low.
- R10: A start that arrives during an access, other than in its ready cycle, is ignored.
- R11: `flash_addr` takes `cpu_addr` when a read is accepted and holds it for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_start | input | 1 | Processor transaction start, one cycle |
| cpu_reg_wr | input | 1 | Transaction is a control register write |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | 8 | Control register write data |
| cpu_ready | output | 1 | Access complete / data ready |
| gpio_burst | input | 1 | External burst-mode level (MODE_SRC=1) |
| flash_wait | input | 1 | Flash not-ready output, used in burst mode |
| flash_addr | output | AW | Address to the flash |
| flash_adv_n | output | 1 | Address-valid strobe, active low |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_clk | output | 1 | Divided memory clock |
| cfg_err | output | 1 | Clock period setting below the flash minimum |
| burst_mode | output | 1 | Current effective read mode (1 = burst) |

## Verification
The bench measures the exact number of not-ready cycles at wait counts of 15, 3, 1 and 0. A design that is off by one, or that skips the address cycle, shows a count that differs from wait-count + 1. It checks that, after the burst switch, a maximal wait count adds no cycles. It also holds the flash wait input high to confirm that ready tracks it rather than a counter. Back-to-back reads are driven in both strobe variants, which catches a strobe that fails to pulse again and a missing chip-enable gap. A mid-access start, a mid-access change of the GPIO level, a register bit that should be ignored and a clock period below the 25 ns limit are each checked. A design that reacts to any of these would show an extra access, a wrong count or a clock that keeps running.

// File: rtl/fwsc_pkg.sv
package fwsc_pkg;

    localparam int WAIT_W = 4;
    localparam int PER_W  = 3;
    localparam int CTRL_W = PER_W + WAIT_W + 1;

    typedef struct packed {
        logic [PER_W-1:0]  clk_per;
        logic [WAIT_W-1:0] wait_n;
        logic              burst_en;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{clk_per: '1, wait_n: '1, burst_en: 1'b0};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_ADDR,
        ST_WAIT,
        ST_DONE,
        ST_BURST,
        ST_REGACK
    } acc_state_e;

    function automatic logic clk_too_fast(input logic [PER_W-1:0] per,
                                          input int sys_ns, input int min_ns);
        return (int'(per) * sys_ns) < min_ns;
    endfunction

endpackage

// File: rtl/fwsc_ctrl_reg.sv
module fwsc_ctrl_reg
    import fwsc_pkg::*;
#(
    parameter int MODE_SRC = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    input  logic              gpio_burst,
    output ctrl_t             ctrl,
    output logic              burst_mode
);
    logic [1:0] gpio_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RESET;
        end else if (we) begin
            ctrl <= ctrl_t'(wdata);
        end
    end

    // two-flop synchronizer for the external level
    always_ff @(posedge clk) begin
        if (rst) begin
            gpio_sync <= 2'b00;
        end else begin
            gpio_sync <= {gpio_sync[0], gpio_burst};
        end
    end

    assign burst_mode = (MODE_SRC == 1) ? gpio_sync[1] : ctrl.burst_en;

endmodule

// File: rtl/fwsc_clk_gen.sv
module fwsc_clk_gen
    import fwsc_pkg::*;
#(
    parameter int SYS_CLK_NS = 20,
    parameter int MIN_CLK_NS = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PER_W-1:0] period,
    output logic             flash_clk,
    output logic             cfg_err
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] cnt_nxt;
    logic [PER_W-1:0] half;

    assign cfg_err = clk_too_fast(period, SYS_CLK_NS, MIN_CLK_NS);
    assign half    = period >> 1;

    always_comb begin
        if (cnt >= period - ONE) begin
            cnt_nxt = '0;
        end else begin
            cnt_nxt = cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_err) begin
            cnt       <= '0;
            flash_clk <= 1'b0;
        end else begin
            cnt       <= cnt_nxt;
            flash_clk <= (cnt_nxt < half);
        end
    end

endmodule

// File: rtl/fwsc_access_fsm.sv
module fwsc_access_fsm
    import fwsc_pkg::*;
#(
    parameter int AW      = 16,
    parameter int USE_ADV = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              reg_wr,
    input  logic [AW-1:0]     addr,
    input  logic              burst_mode,
    input  logic [WAIT_W-1:0] wait_n,
    input  logic              flash_wait,
    output logic              reg_we,
    output logic              ready,
    output logic              adv_n,
    output logic              ce_n,
    output logic [AW-1:0]     faddr,
    output logic              acc_burst
);
    localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

    acc_state_e        st, st_n;
    logic [WAIT_W-1:0] cnt, cnt_n;
    logic              completing;
    logic              accept;
    logic              ce_on;

    assign ce_on      = (st == ST_ADDR) || (st == ST_WAIT) ||
                        (st == ST_DONE) || (st == ST_BURST);
    assign completing = (st == ST_DONE) || (st == ST_REGACK) ||
                        ((st == ST_BURST) && !flash_wait);
    assign accept     = start && ((st == ST_IDLE) || completing);
    assign reg_we     = accept && reg_wr;
    assign ready      = completing;
    assign ce_n       = !ce_on;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            ST_IDLE: st_n = ST_IDLE;
            ST_GAP:  st_n = ST_ADDR;
            ST_ADDR: begin
                if (acc_burst) begin
                    st_n = ST_BURST;
                end else if (wait_n == '0) begin
                    st_n = ST_DONE;
                end else begin
                    st_n  = ST_WAIT;
                    cnt_n = wait_n - ONE;
                end
            end
            ST_WAIT: begin
                if (cnt == '0) begin
                    st_n = ST_DONE;
                end else begin
                    cnt_n = cnt - ONE;
                end
            end
            ST_DONE, ST_REGACK: st_n = ST_IDLE;
            ST_BURST: begin
                if (!flash_wait) begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
        if (accept) begin
            if (reg_wr) begin
                st_n = ST_REGACK;
            end else if ((USE_ADV == 0) && ce_on) begin
                st_n = ST_GAP;
            end else begin
                st_n = ST_ADDR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            faddr     <= '0;
            acc_burst <= 1'b0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (accept && !reg_wr) begin
                faddr     <= addr;
                acc_burst <= burst_mode;
            end
        end
    end

    generate
        if (USE_ADV != 0) begin : g_adv
            assign adv_n = (st != ST_ADDR);
        end else begin : g_no_adv
            assign adv_n = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/flash_boot_wsc.sv
module flash_boot_wsc
    import fwsc_pkg::*;
#(
    parameter int AW         = 16,
    parameter int MODE_SRC   = 0,
    parameter int USE_ADV    = 1,
    parameter int SYS_CLK_NS = 20,
    parameter int MIN_CLK_NS = 25
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_start,
    input  logic          cpu_reg_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [7:0]    cpu_wdata,
    output logic          cpu_ready,
    input  logic          gpio_burst,
    input  logic          flash_wait,
    output logic [AW-1:0] flash_addr,
    output logic          flash_adv_n,
    output logic          flash_ce_n,
    output logic          flash_clk,
    output logic          cfg_err,
    output logic          burst_mode
);
    ctrl_t ctrl;
    logic  reg_we;
    logic  acc_burst;

    fwsc_ctrl_reg #(.MODE_SRC(MODE_SRC)) u_reg (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .wdata      (cpu_wdata[CTRL_W-1:0]),
        .gpio_burst (gpio_burst),
        .ctrl       (ctrl),
        .burst_mode (burst_mode)
    );

    fwsc_access_fsm #(.AW(AW), .USE_ADV(USE_ADV)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (cpu_start),
        .reg_wr     (cpu_reg_wr),
        .addr       (cpu_addr),
        .burst_mode (burst_mode),
        .wait_n     (ctrl.wait_n),
        .flash_wait (flash_wait),
        .reg_we     (reg_we),
        .ready      (cpu_ready),
        .adv_n      (flash_adv_n),
        .ce_n       (flash_ce_n),
        .faddr      (flash_addr),
        .acc_burst  (acc_burst)
    );

    fwsc_clk_gen #(.SYS_CLK_NS(SYS_CLK_NS), .MIN_CLK_NS(MIN_CLK_NS)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .period    (ctrl.clk_per),
        .flash_clk (flash_clk),
        .cfg_err   (cfg_err)
    );

endmodule

// File: rtl/fwsc_checker.sv
module fwsc_checker #(
    parameter int USE_ADV = 1
) (
    input logic clk,
    input logic rst,
    input logic cpu_start,
    input logic cpu_ready,
    input logic flash_wait,
    input logic flash_adv_n,
    input logic flash_ce_n,
    input logic flash_clk,
    input logic cfg_err,
    input logic acc_burst
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flash_ce_n && flash_adv_n && !cpu_ready));

    // R7
    adv_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !flash_adv_n |-> !flash_ce_n);

    // R7
    adv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !flash_adv_n |=> flash_adv_n);

    // R4
    burst_ready_follows_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_ready && flash_wait && !flash_ce_n) |-> !acc_burst);

    // R9
    clk_halt_on_err_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && $past(cfg_err)) |-> !flash_clk);

    generate
        if (USE_ADV != 0) begin : g_adv_chk
            // R7
            adv_from_start_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(flash_adv_n) |-> $past(cpu_start));
        end else begin : g_noadv_chk
            // R8
            adv_idle_chk: assert property (@(posedge clk) disable iff (rst)
                flash_adv_n);
        end
    endgenerate

endmodule

bind flash_boot_wsc fwsc_checker #(.USE_ADV(USE_ADV)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_start   (cpu_start),
    .cpu_ready   (cpu_ready),
    .flash_wait  (flash_wait),
    .flash_adv_n (flash_adv_n),
    .flash_ce_n  (flash_ce_n),
    .flash_clk   (flash_clk),
    .cfg_err     (cfg_err),
    .acc_burst   (acc_burst)
);

// File: tb/flash_boot_wsc_bench.sv
`timescale 1ns/1ps
module flash_boot_wsc_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_start = 1'b0;
    logic          cpu_reg_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0]    cpu_wdata = '0;
    logic          gpio_burst = 1'b0;
    logic          flash_wait = 1'b0;
    logic          sel = 1'b0;

    logic          rdy_a, adv_a, ce_a, fclk_a, err_a, bm_a;
    logic          rdy_b, adv_b, ce_b, fclk_b, err_b, bm_b;
    logic [AW-1:0] fa_a, fa_b;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    flash_boot_wsc #(.AW(AW), .MODE_SRC(0), .USE_ADV(1), .SYS_CLK_NS(20), .MIN_CLK_NS(25)) u_flash_boot_wsc (
        .clk(clk), .rst(rst), .cpu_start(cpu_start && !sel), .cpu_reg_wr(cpu_reg_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(rdy_a),
        .gpio_burst(gpio_burst), .flash_wait(flash_wait), .flash_addr(fa_a),
        .flash_adv_n(adv_a), .flash_ce_n(ce_a), .flash_clk(fclk_a),
        .cfg_err(err_a), .burst_mode(bm_a)
    );

    flash_boot_wsc #(.AW(AW), .MODE_SRC(1), .USE_ADV(0), .SYS_CLK_NS(20), .MIN_CLK_NS(25)) u_flash_boot_wsc_gpio (
        .clk(clk), .rst(rst), .cpu_start(cpu_start && sel), .cpu_reg_wr(cpu_reg_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(rdy_b),
        .gpio_burst(gpio_burst), .flash_wait(flash_wait), .flash_addr(fa_b),
        .flash_adv_n(adv_b), .flash_ce_n(ce_b), .flash_clk(fclk_b),
        .cfg_err(err_b), .burst_mode(bm_b)
    );

    wire          rdy = sel ? rdy_b : rdy_a;
    wire          adv = sel ? adv_b : adv_a;
    wire          ce  = sel ? ce_b  : ce_a;
    wire          bm  = sel ? bm_b  : bm_a;
    wire [AW-1:0] fa  = sel ? fa_b  : fa_a;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive a start at a negedge; returns at the negedge where ready is seen,
    // nr = number of not-ready samples before it.
    task automatic access(input logic rw, input logic [AW-1:0] a, input logic [7:0] d,
                          output int nr);
        cpu_start = 1'b1; cpu_reg_wr = rw; cpu_addr = a; cpu_wdata = d;
        @(posedge clk); @(negedge clk);
        cpu_start = 1'b0; cpu_reg_wr = 1'b0;
        nr = 0;
        while (!rdy && nr < 100) begin
            nr++;
            @(negedge clk);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d, input string req);
        int nr;
        access(1'b1, '0, d, nr);
        chk(req, "register write ready latency", nr, 0);
        chk(req, "ce during register write", int'(ce), 1);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "burst_mode after reset", int'(bm_a), 0);
        chk("R1", "ce_n after reset", int'(ce_a), 1);
        chk("R1", "adv_n after reset", int'(adv_a), 1);
        chk("R1", "ready after reset", int'(rdy_a), 0);
        chk("R1", "cfg_err after reset", int'(err_a), 0);
    endtask

    task automatic t_async_default;
        int nr;
        cpu_start = 1'b1; cpu_addr = 16'h1234;
        @(posedge clk); @(negedge clk);
        cpu_start = 1'b0;
        chk("R7", "adv low in address cycle", int'(adv), 0);
        chk("R2", "ce low in address cycle", int'(ce), 0);
        chk("R11", "flash_addr captured", int'(fa), 16'h1234);
        nr = 1;
        while (!rdy && nr < 100) begin
            @(negedge clk);
            if (!rdy) nr++;
        end
        chk("R1", "not-ready cycles with reset wait count 15", nr, 16);
        chk("R2", "ce low in ready cycle", int'(ce), 0);
        @(negedge clk);
        chk("R2", "ready is one cycle", int'(rdy), 0);
        chk("R2", "ce released after access", int'(ce), 1);
    endtask

    task automatic t_wait_counts;
        int nr;
        wr_reg(8'h60, "R3");  // period 3, wait 0
        access(1'b0, 16'h0001, 8'h00, nr);
        chk("R2", "not-ready cycles with wait 0", nr, 1);
        @(negedge clk);
        wr_reg(8'h66, "R3");  // period 3, wait 3
        access(1'b0, 16'h0002, 8'h00, nr);
        chk("R2", "not-ready cycles with wait 3", nr, 4);
        @(negedge clk);
    endtask

    task automatic t_back_to_back;
        int nr;
        wr_reg(8'h62, "R3");  // period 3, wait 1
        access(1'b0, 16'h00A0, 8'h00, nr);
        chk("R2", "first access wait 1", nr, 2);
        chk("R7", "ce low in ready cycle", int'(ce), 0);
        cpu_start = 1'b1; cpu_addr = 16'h00B0;
        @(posedge clk); @(negedge clk);
        cpu_start = 1'b0;
        chk("R7", "ce held low on back-to-back", int'(ce), 0);
        chk("R7", "adv pulses again", int'(adv), 0);
        chk("R11", "new address on back-to-back", int'(fa), 16'h00B0);
        @(negedge clk);
        chk("R7", "adv high after address cycle", int'(adv), 1);
        @(negedge clk);
        chk("R2", "second access ready", int'(rdy), 1);
        @(negedge clk);
    endtask

    task automatic t_ignore_mid_start;
        int nr;
        wr_reg(8'h66, "R3");
        cpu_start = 1'b1; cpu_addr = 16'h0C00;
        @(posedge clk); @(negedge clk);
        cpu_start = 1'b0;
        @(negedge clk);
        cpu_start = 1'b1; cpu_addr = 16'h0D00;  // in a wait cycle
        @(posedge clk); @(negedge clk);
        cpu_start = 1'b0;
        nr = 2;
        while (!rdy && nr < 100) begin
            nr++;
            @(negedge clk);
        end
        chk("R10", "count unchanged by mid-access start", nr, 4);
        chk("R11", "address held during access", int'(fa), 16'h0C00);
        @(negedge clk);
        chk("R10", "no extra access started", int'(ce), 1);
        chk("R10", "no extra ready", int'(rdy), 0);
    endtask

    task automatic t_gpio_ignored;
        int nr;
        gpio_burst = 1'b1;
        repeat (5) @(negedge clk);
        chk("R5", "gpio ignored with register source", int'(bm_a), 0);
        access(1'b0, 16'h0003, 8'h00, nr);
        chk("R5", "still async with gpio high", nr, 4);
        @(negedge clk);
        gpio_burst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_clock;
        int rises = 0;
        logic prev;
        prev = fclk_a;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (fclk_a && !prev) rises++;
            prev = fclk_a;
        end
        chk("R9", "flash clock rises with period 3", rises, 10);
        chk("R9", "no error with period 3", int'(err_a), 0);
        wr_reg(8'h26, "R3");  // period 1 -> 20 ns < 25 ns
        @(negedge clk);
        chk("R9", "cfg_err for period 1", int'(err_a), 1);
        rises = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (fclk_a) rises++;
        end
        chk("R9", "flash clock held low on error", rises, 0);
        wr_reg(8'h66, "R3");
        chk("R9", "error clears", int'(err_a), 0);
    endtask

    task automatic t_burst;
        int nr;
        wr_reg(8'h7F, "R3");  // period 3, wait 15, burst on
        chk("R4", "burst_mode after register switch", int'(bm_a), 1);
        access(1'b0, 16'h0100, 8'h00, nr);
        chk("R4", "burst read no counted waits", nr, 1);
        @(negedge clk);
        flash_wait = 1'b1;
        cpu_start = 1'b1; cpu_addr = 16'h0104;
        @(posedge clk); @(negedge clk);
        cpu_start = 1'b0;
        chk("R4", "not ready in address cycle", int'(rdy), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R4", "ready low while flash wait high", int'(rdy), 0);
        end
        flash_wait = 1'b0;
        #1;
        chk("R4", "ready follows flash wait release", int'(rdy), 1);
        @(negedge clk);
        chk("R4", "access ends after ready", int'(ce), 1);
    endtask

    task automatic t_gpio_source;
        int nr;
        sel = 1'b1;
        gpio_burst = 1'b0;
        repeat (4) @(negedge clk);
        wr_reg(8'h45, "R3");  // period 2, wait 2, burst bit set
        chk("R5", "register burst bit ignored with gpio source", int'(bm), 0);
        access(1'b0, 16'h0200, 8'h00, nr);
        chk("R5", "async count with gpio low", nr, 3);
        chk("R8", "adv stays high without strobe", int'(adv), 1);
        cpu_start = 1'b1; cpu_addr = 16'h0204;
        @(posedge clk); @(negedge clk);
        cpu_start = 1'b0;
        chk("R8", "ce gap before next address", int'(ce), 1);
        nr = 1;
        while (!rdy && nr < 100) begin
            @(negedge clk);
            if (!rdy) nr++;
        end
        chk("R8", "back-to-back count includes gap", nr, 4);
        @(negedge clk);
        cpu_start = 1'b1; cpu_addr = 16'h0208;
        @(posedge clk); @(negedge clk);
        cpu_start = 1'b0;
        gpio_burst = 1'b1;
        nr = 1;
        while (!rdy && nr < 100) begin
            @(negedge clk);
            if (!rdy) nr++;
        end
        chk("R6", "mid-access mode change ignored", nr, 3);
        repeat (3) @(negedge clk);
        chk("R5", "gpio level selects burst", int'(bm), 1);
        access(1'b0, 16'h020C, 8'h00, nr);
        chk("R5", "burst read after gpio switch", nr, 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_async_default();
        t_wait_counts();
        t_back_to_back();
        t_ignore_mid_start();
        t_gpio_ignored();
        t_clock();
        t_burst();
        t_gpio_source();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule